// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Timer

A single up-counter, 16 or 32 bits wide, shared by three run-time selectable behaviours. In free-run mode it wraps after a programmed top value and compares against a second programmed value, driving a PWM pin whose period follows the top value, whose duty follows the compare value and whose sense a polarity bit can invert. In capture mode, selected transitions on an external pin latch the running count into a capture register. The count can optionally restart from zero on each such edge, which gives pulse widths or periods directly.

In event mode the same counter defines a measurement window of top+1 cycles. A second counter tallies pin events inside the window, and the tally is latched into a result register when the window closes. A fourth mode code is reserved and freezes both counters. Three sticky flags (overflow, compare, capture) are set by the active mode and cleared by a write-one-to-clear strobe. A single interrupt line merges the flags with their enables.

Top module: `cc_timer`

## Requirements
- R1: While reset is asserted and immediately after it, all flags, `irq`, `pwm_out`, `cap_val` and `evt_result` are zero and both counters are zero.
- R2: With `cfg_mode` = 00 (free-run), the counter advances by one per clock. On a clock where it is equal to or above `cfg_top`, it returns to zero and the overflow flag is set. The period is therefore `cfg_top`+1 cycles.
- R3: In free-run mode, on a clock where the counter equals `cfg_cmp`, the compare flag is set.
- R4: `pwm_out` is 0 unless `cfg_pwm_en`=1 and the mode is free-run. When both hold, it equals (counter < `cfg_cmp`) XOR `cfg_pol`. A compare value of zero gives 0% duty and a compare value above the top gives 100% duty before polarity.
- R5: `cap_pin` passes through a two-flop synchroniser and an edge detector. A level driven before clock edge k is acted on at edge k+2. `cfg_edge` selects the events: 00 none, 01 rising, 10 falling, 11 both.
- R6: With `cfg_mode` = 01 (capture), each selected event copies the pre-edge counter value into `cap_val` and sets the capture flag.
- R7: In capture mode the counter wraps at the top and sets the overflow flag as in R2. If `cfg_clr_on_cap`=1, an event clears the counter to zero instead of advancing it; if it is 0, counting continues.
- R8: With `cfg_mode` = 10 (event count), each event increments the event counter. On the clock where the timer is at or above the top, the event count is copied to `evt_result`, the overflow flag is set and the timer restarts at zero.
- R9: An event on the same clock as a window end is excluded from the latched result and becomes the first count of the new window.
- R10: With `cfg_mode` = 11 (reserved), the timer and event counter hold their values, no flag is set, and `cap_val` and `evt_result` do not change.
- R11: Flags are sticky. `flag_clr` bit 0 clears overflow, bit 1 clears compare and bit 2 clears capture. A flag set condition on the same clock as its clear wins.
- R12: `irq` is high when any flag is high together with its enable (`cfg_ie_ovf`, `cfg_ie_cmp`, `cfg_ie_cap`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Mode: 00 free-run, 01 capture, 10 event count, 11 hold |
| cfg_edge | input | 2 | Event edge select: 00 none, 01 rise, 10 fall, 11 both |
| cfg_top | input | W | Wrap / window end value |
| cfg_cmp | input | W | Compare value for flag and PWM duty |
| cfg_clr_on_cap | input | 1 | Clear counter on capture event |
| cfg_pol | input | 1 | Invert PWM output |
| cfg_pwm_en | input | 1 | Enable PWM output |
| cfg_ie_ovf | input | 1 | Overflow interrupt enable |
| cfg_ie_cmp | input | 1 | Compare interrupt enable |
| cfg_ie_cap | input | 1 | Capture interrupt enable |
| cap_pin | input | 1 | Asynchronous capture / event pin |
| flag_clr | input | 3 | Write-one-to-clear strobe: bit0 ovf, bit1 cmp, bit2 cap |
| pwm_out | output | 1 | PWM waveform |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_cmp | output | 1 | Sticky compare flag |
| flag_cap | output | 1 | Sticky capture flag |
| irq | output | 1 | Merged interrupt |
| cap_val | output | W | Last captured counter value |
| evt_result | output | W | Event count of the last closed window |

## Verification
The hardest situation to reach is an event that lands exactly on a window-end clock, because the pin passes through two synchroniser stages before it is seen. The bench reaches it by reset-aligning the counter, then placing a single rising edge three clocks before the sixth edge. The result latched at that window must read 0, and the next window must read 1. An exact capture interval is set up the same way with clear-on-capture, and two rises twelve clocks apart must capture 11. Beyond these directed cases, a behavioural model tracks every mode under pseudo-random pin activity and compares all outputs on each clock.

// File: rtl/cct_pkg.sv
package cct_pkg;
   typedef enum logic [1:0] {
      MODE_FREE = 2'b00,
      MODE_CAPT = 2'b01,
      MODE_EVT  = 2'b10,
      MODE_HOLD = 2'b11
   } cct_mode_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } cct_edge_e;

   localparam int FLAG_OVF = 0;
   localparam int FLAG_CMP = 1;
   localparam int FLAG_CAP = 2;
   localparam int N_FLAGS  = 3;
endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync
   import cct_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sel_i,
   output logic       evt_o
);
   localparam int CHAIN = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cct_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN-1:0] chain_q;
   logic             lvl, prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], pin_i};
   end

   assign lvl  = chain_q[STAGES-1];
   assign prev = chain_q[STAGES];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      case (sel_i)
         EDGE_RISE: evt_o = rise;
         EDGE_FALL: evt_o = fall;
         EDGE_BOTH: evt_o = rise | fall;
         default:   evt_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cct_core.sv
module cct_core
   import cct_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_i,
   input  logic [W-1:0]        top_i,
   input  logic [W-1:0]        cmp_i,
   input  logic                clr_on_cap_i,
   input  logic                evt_i,
   output logic [W-1:0]        cnt_o,
   output logic [N_FLAGS-1:0]  set_o,
   output logic [W-1:0]        cap_o,
   output logic [W-1:0]        res_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q, cnt_d, ecnt_q, ecnt_d, cap_q, cap_d, res_q, res_d;
   logic         at_top;

   assign at_top = (cnt_q >= top_i);

   always_comb begin
      cnt_d  = cnt_q;
      ecnt_d = ecnt_q;
      cap_d  = cap_q;
      res_d  = res_q;
      set_o  = '0;
      case (mode_i)
         MODE_FREE: begin
            set_o[FLAG_OVF] = at_top;
            set_o[FLAG_CMP] = (cnt_q == cmp_i);
            cnt_d           = at_top ? '0 : cnt_q + ONE;
         end
         MODE_CAPT: begin
            set_o[FLAG_OVF] = at_top;
            if (evt_i) begin
               cap_d           = cnt_q;
               set_o[FLAG_CAP] = 1'b1;
            end
            if ((evt_i && clr_on_cap_i) || at_top) cnt_d = '0;
            else                                    cnt_d = cnt_q + ONE;
         end
         MODE_EVT: begin
            if (at_top) begin
               set_o[FLAG_OVF] = 1'b1;
               res_d           = ecnt_q;
               ecnt_d          = W'(evt_i);
               cnt_d           = '0;
            end else begin
               ecnt_d = ecnt_q + W'(evt_i);
               cnt_d  = cnt_q + ONE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ecnt_q <= '0;
         cap_q  <= '0;
         res_q  <= '0;
      end else begin
         cnt_q  <= cnt_d;
         ecnt_q <= ecnt_d;
         cap_q  <= cap_d;
         res_q  <= res_d;
      end
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;
   assign res_o = res_q;

   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_FREE && cnt_q >= top_i) |=> (cnt_q == '0)); // R2
   AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_CAPT && evt_i) |=> (cap_q == $past(cnt_q))); // R6
   AST_WIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_EVT && cnt_q >= top_i) |=> (res_q == $past(ecnt_q))); // R8
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_HOLD) |=> (cnt_q == $past(cnt_q) && ecnt_q == $past(ecnt_q))); // R10
endmodule

// File: rtl/cct_flags.sv
module cct_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] ie_i,
   output logic [N-1:0] flag_o,
   output logic         irq_o
);
   logic [N-1:0] flag_q;

   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
         end

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i[g]) |=> flag_q[g]); // R11
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]); // R11
      end
   endgenerate

   assign flag_o = flag_q;
   assign irq_o  = |(flag_q & ie_i);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import cct_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   cfg_mode,
   input  logic [1:0]   cfg_edge,
   input  logic [W-1:0] cfg_top,
   input  logic [W-1:0] cfg_cmp,
   input  logic         cfg_clr_on_cap,
   input  logic         cfg_pol,
   input  logic         cfg_pwm_en,
   input  logic         cfg_ie_ovf,
   input  logic         cfg_ie_cmp,
   input  logic         cfg_ie_cap,
   input  logic         cap_pin,
   input  logic [2:0]   flag_clr,
   output logic         pwm_out,
   output logic         flag_ovf,
   output logic         flag_cmp,
   output logic         flag_cap,
   output logic         irq,
   output logic [W-1:0] cap_val,
   output logic [W-1:0] evt_result
);
   generate
      if (W != 16 && W != 32) begin : g_bad_width
         $error("cc_timer: W must be 16 or 32");
      end
   endgenerate

   logic                evt;
   logic [W-1:0]        cnt;
   logic [N_FLAGS-1:0]  set_vec, flags, ie_vec;

   cct_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (cap_pin),
      .sel_i (cfg_edge),
      .evt_o (evt)
   );

   cct_core #(.W(W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (cfg_mode),
      .top_i        (cfg_top),
      .cmp_i        (cfg_cmp),
      .clr_on_cap_i (cfg_clr_on_cap),
      .evt_i        (evt),
      .cnt_o        (cnt),
      .set_o        (set_vec),
      .cap_o        (cap_val),
      .res_o        (evt_result)
   );

   assign ie_vec[FLAG_OVF] = cfg_ie_ovf;
   assign ie_vec[FLAG_CMP] = cfg_ie_cmp;
   assign ie_vec[FLAG_CAP] = cfg_ie_cap;

   cct_flags #(.N(N_FLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (flag_clr),
      .ie_i   (ie_vec),
      .flag_o (flags),
      .irq_o  (irq)
   );

   assign flag_ovf = flags[FLAG_OVF];
   assign flag_cmp = flags[FLAG_CMP];
   assign flag_cap = flags[FLAG_CAP];

   always_comb begin
      if (cfg_pwm_en && cfg_mode == MODE_FREE) pwm_out = (cnt < cfg_cmp) ^ cfg_pol;
      else                                     pwm_out = 1'b0;
   end

   AST_PWM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pwm_en || cfg_mode != MODE_FREE) |-> !pwm_out); // R4
endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
   localparam int W = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic [1:0]   cfg_mode = 2'b00, cfg_edge = 2'b00;
   logic [W-1:0] cfg_top = '0, cfg_cmp = '0;
   logic         cfg_clr_on_cap = 0, cfg_pol = 0, cfg_pwm_en = 0;
   logic         cfg_ie_ovf = 0, cfg_ie_cmp = 0, cfg_ie_cap = 0;
   logic         cap_pin = 0;
   logic [2:0]   flag_clr = '0;
   logic         pwm_out, flag_ovf, flag_cmp, flag_cap, irq;
   logic [W-1:0] cap_val, evt_result;

   cc_timer #(.W(W)) uut (.*);

   int    checks = 0, errors = 0, cycles = 0;
   string tag = "R1";
   bit    compare_on = 1'b1;

   // behavioural reference state
   int       m_cnt = 0, m_ecnt = 0, m_res = 0, m_cap = 0;
   bit [2:0] m_f = '0;
   bit       p1 = 0, p2 = 0, p3 = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   always @(posedge clk) begin : ref_model
      bit       ev;
      bit [2:0] set;
      int       top, cmp;
      if (!rst_n) begin
         m_cnt = 0; m_ecnt = 0; m_res = 0; m_cap = 0; m_f = '0;
         p1 = 0; p2 = 0; p3 = 0;
      end else begin
         top = int'(cfg_top);
         cmp = int'(cfg_cmp);
         case (cfg_edge)
            2'b01:   ev = p2 && !p3;
            2'b10:   ev = !p2 && p3;
            2'b11:   ev = (p2 != p3);
            default: ev = 1'b0;
         endcase
         set = '0;
         case (cfg_mode)
            2'b00: begin
               set[1] = (m_cnt == cmp);
               if (m_cnt >= top) begin set[0] = 1; m_cnt = 0; end
               else m_cnt++;
            end
            2'b01: begin
               if (ev) begin m_cap = m_cnt; set[2] = 1; end
               if (m_cnt >= top) set[0] = 1;
               if ((ev && cfg_clr_on_cap) || m_cnt >= top) m_cnt = 0;
               else m_cnt++;
            end
            2'b10: begin
               if (m_cnt >= top) begin
                  set[0] = 1; m_res = m_ecnt; m_ecnt = ev ? 1 : 0; m_cnt = 0;
               end else begin
                  m_cnt++; m_ecnt += ev ? 1 : 0;
               end
            end
            default: ;
         endcase
         m_f = (m_f & ~flag_clr) | set;
         p3 = p2; p2 = p1; p1 = cap_pin;
      end
   end

   always @(posedge clk) begin : compare_each_cycle
      bit exp_pwm;
      #2;
      if (compare_on) begin
         exp_pwm = (cfg_pwm_en && cfg_mode == 2'b00) ? ((m_cnt < int'(cfg_cmp)) ^ cfg_pol) : 1'b0;
         chk({"R4 pwm_out ", tag}, pwm_out, exp_pwm);
         chk({"R2 R7 R8 flag_ovf ", tag}, flag_ovf, m_f[0]);
         chk({"R3 flag_cmp ", tag}, flag_cmp, m_f[1]);
         chk({"R6 flag_cap ", tag}, flag_cap, m_f[2]);
         chk({"R12 irq ", tag}, irq,
             |(m_f & {cfg_ie_cap, cfg_ie_cmp, cfg_ie_ovf}));
         chk({"R6 R7 cap_val ", tag}, cap_val, m_cap);
         chk({"R8 R9 evt_result ", tag}, evt_result, m_res);
      end
   end

   always @(posedge clk) begin : watchdog
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog expired actual %0d expected below 50000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rand_pin(int n);
      repeat (n) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cap_pin = lfsr[0];
      end
   endtask

   task automatic toggle_pin(int n);
      repeat (n) begin
         @(negedge clk);
         cap_pin = ~cap_pin;
      end
   endtask

   initial begin : stimulus
      logic [W-1:0] keep_cap, keep_res;
      logic [2:0]   keep_f;

      // R1: reset state
      cyc(3);
      chk("R1 reset flags", {flag_cap, flag_cmp, flag_ovf}, 0);
      chk("R1 reset irq", irq, 0);
      chk("R1 reset pwm", pwm_out, 0);
      chk("R1 reset cap_val", cap_val, 0);
      chk("R1 reset evt_result", evt_result, 0);
      rst_n = 1'b1;

      // free-run with compare and PWM
      tag = "R2 R3 R4 R11 R12";
      cfg_mode = 2'b00; cfg_top = 9; cfg_cmp = 4; cfg_pwm_en = 1; cfg_ie_ovf = 1;
      cyc(25);
      chk("R2 overflow flag after wrap", flag_ovf, 1);
      chk("R12 irq from overflow", irq, 1);
      flag_clr = 3'b011; cyc(1); flag_clr = '0;
      cfg_ie_cmp = 1; cyc(17);
      cfg_pol = 1; cfg_cmp = 0; tag = "R4 zero duty inverted"; cyc(12);
      cfg_cmp = 12; tag = "R4 full duty"; cyc(12);
      cfg_pol = 0; cyc(12);
      cfg_pwm_en = 0; tag = "R4 disabled"; cyc(6);

      // R11: flags hold in the reserved mode, then clear
      cfg_mode = 2'b11; tag = "R10 R11 hold"; cyc(2);
      keep_f = {flag_cap, flag_cmp, flag_ovf};
      cyc(10);
      chk("R11 flags sticky", {flag_cap, flag_cmp, flag_ovf}, keep_f);
      flag_clr = 3'b111; cyc(1); flag_clr = '0; cyc(1);
      chk("R11 flags cleared", {flag_cap, flag_cmp, flag_ovf}, 0);

      // capture mode under several edge selections
      cfg_mode = 2'b01; cfg_top = 200; cfg_ie_cap = 1; cfg_edge = 2'b01;
      tag = "R5 R6 R7 rise noclear"; rand_pin(60);
      cfg_clr_on_cap = 1; tag = "R5 R7 rise clear"; rand_pin(60);
      cfg_edge = 2'b10; tag = "R5 fall"; rand_pin(40);
      cfg_edge = 2'b11; tag = "R5 both"; rand_pin(40);
      cfg_edge = 2'b00; tag = "R5 none"; rand_pin(40);
      cfg_top = 13; cfg_edge = 2'b01; cfg_clr_on_cap = 0;
      tag = "R7 wrap in capture"; rand_pin(60);

      // R7 directed: two rises twelve clocks apart with clear-on-capture
      cfg_top = 200; cfg_clr_on_cap = 1; cfg_edge = 2'b01; tag = "R7 interval";
      cap_pin = 0; cyc(6);
      cap_pin = 1; cyc(6);
      cap_pin = 0; cyc(6);
      cap_pin = 1; cyc(3);
      chk("R7 capture interval of twelve", cap_val, 11);
      cyc(4);

      // R8/R9 directed: event exactly on window end after reset alignment
      compare_on = 0; rst_n = 0; cap_pin = 0; cyc(2);
      cfg_mode = 2'b10; cfg_top = 5; cfg_edge = 2'b01; tag = "R8 R9 aligned";
      rst_n = 1; compare_on = 1;
      cyc(3);
      cap_pin = 1;
      cyc(3);
      chk("R9 boundary event left out of closing window", evt_result, 0);
      cyc(6);
      chk("R9 boundary event counted in next window", evt_result, 1);
      cyc(6);
      chk("R8 empty window", evt_result, 0);

      // event mode under pseudo-random activity
      cfg_top = 20; tag = "R8 rise random"; rand_pin(70);
      cfg_edge = 2'b11; cfg_top = 3; tag = "R8 R9 both toggle"; toggle_pin(30);
      cfg_top = 17; tag = "R8 both random"; rand_pin(60);

      // R10: reserved mode freezes everything
      cfg_mode = 2'b11; tag = "R10 hold";
      flag_clr = 3'b111; cyc(1); flag_clr = '0;
      keep_cap = cap_val; keep_res = evt_result;
      rand_pin(30);
      chk("R10 cap_val frozen", cap_val, keep_cap);
      chk("R10 evt_result frozen", evt_result, keep_res);
      chk("R10 no flag set", {flag_cap, flag_cmp, flag_ovf}, 0);

      // resume free-run from the held count
      cfg_mode = 2'b00; cfg_top = 9; cfg_cmp = 5; cfg_pwm_en = 1;
      tag = "R2 R3 R4 resume"; cyc(30);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule